// File: doc/BRIEF.md
# Colour Matrix Coefficient Q3.12 Converter

This block takes colour-matrix coefficients one at a time, each a 64-bit sign-magnitude fixed-point number with 32 fractional bits. It turns each one into the 15-bit two's-complement Q3.12 form that a pixel colour-adjust stage loads. Each coefficient is presented for one cycle with a valid strobe. One cycle later the block returns the converted value and a flag that says whether the value can be represented. Nine coefficients in a row make up one 3×3 matrix.

The block counts coefficients into sets of nine. It keeps the nine results on a flat output bus, and it pulses a done strobe after the ninth coefficient. A set-accepted flag is high only when no coefficient in the set was rejected. The range check runs after the conversion to two's complement: the sign is compared with the top bit of the 15-bit result. Because of this, negative values down to -4.0 are accepted, and a check on the magnitude alone would wrongly reject them.

Top module: `cmq_conv_top`

## Requirements
- R1: The magnitude field is input bits 34:20. Bits 19:0 are truncated and bits 62:35 are ignored. With bit 63 clear, the result equals that 15-bit field.
- R2: With bit 63 set, the result is the 15-bit two's-complement negation of the magnitude field, wrapping modulo 2^15.
- R3: With bit 63 clear, a magnitude field of 0x4000 or more raises the reject flag.
- R4: With bit 63 set, magnitude fields from 1 to 0x4000 are accepted, including 0x2000 and 0x4000. Fields above 0x4000 are rejected.
- R5: A negative zero (bit 63 set, magnitude field 0) gives result 0 and is accepted.
- R6: The result, the reject flag and the result strobe appear exactly one clock after the coefficient's valid strobe. Idle cycles in between have no effect.
- R7: Every ninth accepted strobe closes a set. The done output is high for exactly the one clock after that strobe.
- R8: The set-accepted flag rises together with the done pulse only if none of the nine coefficients was rejected. It stays stable until it clears in the clock after the first coefficient of the next set.
- R9: Slot k of the matrix bus (bits 15k+14:15k) holds the result of the k-th coefficient (k = 0..8) of the latest set, written whether or not it was rejected. It is unchanged on clocks without a valid strobe.
- R10: After reset, all outputs are zero and the next coefficient is counted as slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coefValid | input | 1 | Coefficient present this cycle |
| coefIn | input | 64 | Sign-magnitude coefficient, bit 63 sign, 32 fractional bits |
| coefOut | output | 15 | Converted Q3.12 two's-complement value |
| coefErr | output | 1 | Coefficient not representable |
| coefOutValid | output | 1 | coefOut and coefErr are fresh this cycle |
| setDone | output | 1 | One-cycle pulse after the ninth coefficient of a set |
| setOk | output | 1 | Last completed set had no rejected coefficient |
| matrixFlat | output | 135 | Nine 15-bit results, slot 0 in the low bits |

## Verification
A slot counter that has slipped would write results to the wrong matrix slot and move the done pulse. This would show on the matrix bus at the first coefficient after the slip, and on setDone within nine coefficients. A sticky reject state that was stuck or cleared would show on setOk at the next done pulse. The per-coefficient conversion and range check show on coefOut and coefErr one clock after each strobe. The cases that matter most are 0x2000, 0x4000, 0x4001 and negative zero.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic capture;   // a coefficient is taken this cycle
    logic startSet;  // it is slot 0 of a set
    logic closeSet;  // it is the last slot of a set
  } cmqStrobe_t;
endpackage

// File: rtl/cmq_ctrl.sv
module cmq_ctrl
  import cmq_pkg::*;
#(
  parameter int NCOEF = 9,
  parameter int IDX_W = (NCOEF > 1) ? $clog2(NCOEF) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coefValid,
  output cmqStrobe_t       strb,
  output logic [IDX_W-1:0] slotIdx,
  output logic             setDone
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCOEF - 1);

  logic [IDX_W-1:0] idxQ;

  always_comb begin
    strb.capture  = coefValid;
    strb.startSet = coefValid && (idxQ == '0);
    strb.closeSet = coefValid && (idxQ == LAST_IDX);
  end

  assign slotIdx = idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= '0;
      setDone <= 1'b0;
    end else begin
      setDone <= strb.closeSet;
      if (strb.closeSet)     idxQ <= '0;
      else if (strb.capture) idxQ <= idxQ + 1'b1;
    end
  end
endmodule

// File: rtl/cmq_datapath.sv
module cmq_datapath
  import cmq_pkg::*;
#(
  parameter int IN_W     = 64,
  parameter int FRAC_IN  = 32,
  parameter int FRAC_OUT = 12,
  parameter int OUT_W    = 15,
  parameter int NCOEF    = 9,
  parameter int IDX_W    = (NCOEF > 1) ? $clog2(NCOEF) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IN_W-1:0]        coefIn,
  input  cmqStrobe_t             strb,
  input  logic [IDX_W-1:0]       slotIdx,
  output logic [OUT_W-1:0]       coefOut,
  output logic                   coefErr,
  output logic                   coefOutValid,
  output logic                   setOk,
  output logic [NCOEF*OUT_W-1:0] matrixFlat
);
  localparam int SHIFT    = FRAC_IN - FRAC_OUT;
  localparam int SIGN_BIT = IN_W - 1;

  logic             signBit;
  logic [OUT_W-1:0] mag;
  logic [OUT_W-1:0] conv;
  logic             isNegZero;
  logic             rangeErr;
  logic             errSticky;
  logic             errSetNext;

  // truncating conversion, then range check on the converted word
  always_comb begin
    signBit    = coefIn[SIGN_BIT];
    mag        = coefIn[SHIFT +: OUT_W];
    conv       = signBit ? (~mag + OUT_W'(1)) : mag;
    isNegZero  = signBit && (mag == '0);
    rangeErr   = (signBit != conv[OUT_W-1]) && !isNegZero;
    errSetNext = strb.startSet ? rangeErr : (errSticky | rangeErr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefOut      <= '0;
      coefErr      <= 1'b0;
      coefOutValid <= 1'b0;
      errSticky    <= 1'b0;
      setOk        <= 1'b0;
    end else begin
      coefOutValid <= strb.capture;
      if (strb.capture) begin
        coefOut   <= conv;
        coefErr   <= rangeErr;
        errSticky <= errSetNext;
      end
      if (strb.closeSet)      setOk <= !errSetNext;
      else if (strb.startSet) setOk <= 1'b0;
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_slot
    logic [OUT_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                       slotQ <= '0;
      else if (strb.capture && slotIdx == IDX_W'(k))   slotQ <= conv;
    end
    assign matrixFlat[k*OUT_W +: OUT_W] = slotQ;
  end
endmodule

// File: rtl/cmq_conv_top.sv
module cmq_conv_top
  import cmq_pkg::*;
#(
  parameter int IN_W     = 64,
  parameter int FRAC_IN  = 32,
  parameter int FRAC_OUT = 12,
  parameter int OUT_W    = 15,
  parameter int NCOEF    = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   coefValid,
  input  logic [IN_W-1:0]        coefIn,
  output logic [OUT_W-1:0]       coefOut,
  output logic                   coefErr,
  output logic                   coefOutValid,
  output logic                   setDone,
  output logic                   setOk,
  output logic [NCOEF*OUT_W-1:0] matrixFlat
);
  localparam int IDX_W = (NCOEF > 1) ? $clog2(NCOEF) : 1;

  cmqStrobe_t       strb;
  logic [IDX_W-1:0] slotIdx;

  cmq_ctrl #(.NCOEF(NCOEF), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .coefValid(coefValid),
    .strb(strb), .slotIdx(slotIdx), .setDone(setDone)
  );

  cmq_datapath #(
    .IN_W(IN_W), .FRAC_IN(FRAC_IN), .FRAC_OUT(FRAC_OUT),
    .OUT_W(OUT_W), .NCOEF(NCOEF), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .coefIn(coefIn), .strb(strb), .slotIdx(slotIdx),
    .coefOut(coefOut), .coefErr(coefErr), .coefOutValid(coefOutValid),
    .setOk(setOk), .matrixFlat(matrixFlat)
  );
endmodule

// File: rtl/cmq_conv_chk.sv
module cmq_conv_chk #(
  parameter int IN_W     = 64,
  parameter int FRAC_IN  = 32,
  parameter int FRAC_OUT = 12,
  parameter int OUT_W    = 15,
  parameter int NCOEF    = 9
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   coefValid,
  input logic [IN_W-1:0]        coefIn,
  input logic [OUT_W-1:0]       coefOut,
  input logic                   coefErr,
  input logic                   coefOutValid,
  input logic                   setDone,
  input logic                   setOk,
  input logic [NCOEF*OUT_W-1:0] matrixFlat
);
  localparam int SHIFT = FRAC_IN - FRAC_OUT;

  // R6
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    coefValid |=> coefOutValid);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coefValid |=> !coefOutValid);
  // R5
  zero_mag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coefValid && coefIn[SHIFT +: OUT_W] == '0) |=> (coefOut == '0 && !coefErr));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    setDone |=> !setDone);
  // R7
  done_with_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    setDone |-> coefOutValid);
  // R8
  reject_blocks_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setDone && coefErr) |-> !setOk);
  // R8
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coefValid |=> $stable(setOk));
  // R9
  matrix_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coefValid |=> $stable(matrixFlat));
endmodule

bind cmq_conv_top cmq_conv_chk #(
  .IN_W(IN_W), .FRAC_IN(FRAC_IN), .FRAC_OUT(FRAC_OUT), .OUT_W(OUT_W), .NCOEF(NCOEF)
) u_chk (
  .clk(clk), .rstN(rstN), .coefValid(coefValid), .coefIn(coefIn),
  .coefOut(coefOut), .coefErr(coefErr), .coefOutValid(coefOutValid),
  .setDone(setDone), .setOk(setOk), .matrixFlat(matrixFlat)
);

// File: tb/test_cmq_conv_top.sv
module test_cmq_conv_top;
  localparam int NC = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          coefValid = 1'b0;
  logic [63:0]   coefIn = '0;
  logic [14:0]   coefOut;
  logic          coefErr, coefOutValid, setDone, setOk;
  logic [NC*15-1:0] matrixFlat;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  cmq_conv_top i_cmq_conv_top (
    .clk(clk), .rstN(rstN), .coefValid(coefValid), .coefIn(coefIn),
    .coefOut(coefOut), .coefErr(coefErr), .coefOutValid(coefOutValid),
    .setDone(setDone), .setOk(setOk), .matrixFlat(matrixFlat)
  );

  // behavioural reference state
  logic [14:0] mOut;
  bit          mErr, mVld, mDone, mOk, mErrAcc;
  int          mIdx;
  logic [14:0] mSlot [NC];

  // R1 R2 R3 R4 R5: numeric model of the conversion
  function automatic void refConv(input logic [63:0] v, output logic [14:0] r, output bit e);
    int q;
    q = int'((v >> 20) & 64'h7fff);
    if (v[63]) begin
      e = (q > 16384);
      r = 15'((32768 - q) % 32768);
    end else begin
      e = (q >= 16384);
      r = 15'(q);
    end
  endfunction

  always @(posedge clk) begin
    logic [14:0] r;
    bit e;
    cyc++;
    if (!rstN) begin
      mOut = '0; mErr = 0; mVld = 0; mDone = 0; mOk = 0; mErrAcc = 0; mIdx = 0;
      foreach (mSlot[k]) mSlot[k] = '0;
    end else begin
      mVld  = coefValid;
      mDone = coefValid && (mIdx == NC - 1);
      if (coefValid) begin
        refConv(coefIn, r, e);
        mOut = r; mErr = e;
        mSlot[mIdx] = r;
        if (mIdx == 0) begin mErrAcc = e; mOk = 0; end
        else mErrAcc = mErrAcc | e;
        if (mIdx == NC - 1) begin mOk = !mErrAcc; mIdx = 0; end
        else mIdx++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [NC*15-1:0] act, input logic [NC*15-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    logic [NC*15-1:0] expM;
    for (int k = 0; k < NC; k++) expM[k*15 +: 15] = mSlot[k];
    chk(coefOut == mOut, "R1/R2 coefOut", NC*15'(coefOut), NC*15'(mOut));
    chk(coefErr == mErr, "R3/R4/R5 coefErr", NC*15'(coefErr), NC*15'(mErr));
    chk(coefOutValid == mVld, "R6 coefOutValid", NC*15'(coefOutValid), NC*15'(mVld));
    chk(setDone == mDone, "R7 setDone", NC*15'(setDone), NC*15'(mDone));
    chk(setOk == mOk, "R8 setOk", NC*15'(setOk), NC*15'(mOk));
    chk(matrixFlat == expM, "R9 matrixFlat", matrixFlat, expM);
  end

  function automatic logic [63:0] mk(input bit s, input int q, input logic [63:0] extra);
    return {s, 63'(0)} | (64'(q & 32'h7fff) << 20) | extra;
  endfunction

  task automatic send(input logic [63:0] v, input int gap);
    coefValid = 1'b1; coefIn = v;
    @(negedge clk);
    coefValid = 1'b0; coefIn = 64'hdead_beef_0bad_f00d;  // ignored while idle (R6)
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  initial begin : watchdog
    #100000;
    mismatched++;
    $display("FAIL R6 watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    lfsr = 64'h1234_5678_9abc_def1;
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk(coefOut == '0 && !coefErr && !coefOutValid && !setDone && !setOk && matrixFlat == '0,
        "R10 reset", matrixFlat, '0);
    rstN = 1'b1;
    @(negedge clk);
    // Set 1: all accepted, boundary values, gaps between strobes
    send(mk(0, 0, 64'h0), 1);                         // zero
    send(mk(0, 16'h1000, 64'hf_ffff), 2);              // +1.0 with truncated fraction (R1)
    send(mk(1, 16'h1000, 64'h0), 0);                   // -1.0 (R2)
    send(mk(1, 16'h2000, 64'h0), 1);                   // -2.0 accepted (R4)
    send(mk(1, 16'h4000, 64'h0), 0);                   // -4.0 accepted (R4)
    send(mk(1, 0, 64'h3), 0);                          // negative zero (R5)
    send(mk(0, 16'h3fff, 64'h0), 0);                   // largest positive
    send(mk(1, 1, 64'h0), 3);                          // smallest negative
    send(mk(0, 5, 64'h1 << 40), 4);                    // upper bits ignored (R1)
    // Set 2: rejections (R3 R4 R8)
    send(mk(0, 16'h4000, 64'h0), 0);                   // +4.0 rejected (R3)
    send(mk(1, 16'h4001, 64'h0), 0);                   // below -4.0 rejected (R4)
    for (int k = 0; k < NC - 2; k++) send(mk(k[0], k * 300, 64'h0), 0);
    repeat (3) @(negedge clk);
    // Set 3: all accepted, back-to-back, setOk clears then returns (R8)
    for (int k = 0; k < NC; k++) send(mk(k[1], 16'h0800 + k * 17, 64'h0), 0);
    repeat (2) @(negedge clk);
    // Sets 4..13: pseudo-random coefficients
    for (int n = 0; n < 10 * NC; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      send({lfsr[63], 28'(lfsr[40:13]), lfsr[42], lfsr[34:0]} & ((n % 3 == 0) ? 64'hffff_ffff_ffff_ffff : 64'h8000_0003_ffff_ffff),
           int'(lfsr[1:0] & {lfsr[5], 1'b1} & 2'b01));
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule